// File: doc/BRIEF.md
# Microcontroller Data Memory Access Router

This block stands between an 8-bit microcontroller core and the storage that the core reaches for data. For each request the core gives an access kind, a 16-bit address, write data and a write flag. The router then sends the access to one of five targets: the lower internal RAM, the upper internal RAM, the special-function-register port, a 256-byte on-chip expanded RAM, or a multiplexed external bus. The router returns the read data of the chosen target to the core. The two 128-byte internal RAM halves and the expanded RAM are held inside the block.

Two routing rules depend on context rather than on the address alone. In the 80h–FFh window, a direct access reaches the register port and an indirect access reaches the upper RAM. These are two separate stores that share the same addresses. External-move accesses below 100h are served by the on-chip expanded RAM unless the bypass bit is set. When the bit is set, every external-move access goes out on the bus. Internal accesses complete in the cycle of the request. An external access runs as a fixed three-phase sequence, and the router holds `ready` low until the release phase.

Access kind encoding on `reqType`: 0 = direct, 1 = indirect, 2 = external move through an 8-bit register pointer, 3 = external move through a 16-bit data pointer.

Top module: `mem_access_router`

## Requirements
- R1: Direct (0) and indirect (1) accesses with address bits 7:0 in 00h–7Fh read and write one shared 128-byte lower RAM, indexed by bits 6:0. Address bits 15:8 are ignored.
- R2: Indirect accesses with bits 7:0 in 80h–FFh reach a 128-byte upper RAM that direct accesses to the same addresses never modify.
- R3: Direct accesses with bits 7:0 in 80h–FFh raise `sfrSel` in that cycle, with `sfrAddr`/`sfrWdata` equal to the request and `sfrWe` equal to `reqWrite`. A read returns `sfrRdata` on `rdata`. `sfrSel` is low for every other access.
- R4: The bypass bit is 0 after reset. A cycle with `cfgWe` high loads `cfgVal` at that clock edge. The new value routes requests only from the next cycle onward.
- R5: With the bypass bit at 0, pointer moves (3) below 100h and every register-pointer move (2) use the 256-byte expanded RAM, indexed by address bits 7:0. A register-pointer move and a data-pointer move with the same low byte reach the same byte.
- R6: With the bypass bit at 0, data-pointer moves at 0100h–FFFFh go to the external bus.
- R7: With the bypass bit at 1, every external move (2 and 3) goes to the external bus, including addresses below 100h.
- R8: Accesses served internally leave the bus idle: `extAle`=0, `extRdN`=`extWrN`=1, `extLoOe`=`extHiOe`=0.
- R9: An external access shows `ready`=0 in its request cycle. The three cycles that follow are the phases below.
  - Address phase: `extAle`=1, `extLo`=address low byte, `extLoOe`=1.
  - Strobe phase: a write drives `extWrN`=0 with `extLo`=write data and `extLoOe`=1; a read drives `extRdN`=0 with `extLoOe`=0.
  - Release phase: the bus is idle and `ready`=1.
  - In the address and strobe phases, a data-pointer move drives `extHi`=address high byte with `extHiOe`=1. A register-pointer move keeps `extHiOe`=0.
- R10: For an external read, `extLoIn` is sampled at the clock edge that ends the strobe phase and is shown on `rdata` during the release phase.
- R11: Internal accesses show `ready`=1 in the request cycle. A write takes effect at that clock edge. Read data is on `rdata` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present; held until `ready` |
| reqType | input | 2 | Access kind (0 direct, 1 indirect, 2 register-pointer move, 3 data-pointer move) |
| reqAddr | input | 16 | Request address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 8 | Write data |
| rdata | output | 8 | Read data from the selected target |
| ready | output | 1 | Request completes at the next edge when high |
| cfgWe | input | 1 | Load the bypass bit |
| cfgVal | input | 1 | New bypass bit value |
| sfrSel | output | 1 | Register-port access this cycle |
| sfrWe | output | 1 | Register-port write |
| sfrAddr | output | 8 | Register-port address |
| sfrWdata | output | 8 | Register-port write data |
| sfrRdata | input | 8 | Register-port read data |
| extAle | output | 1 | External address latch enable |
| extRdN | output | 1 | External read strobe, active low |
| extWrN | output | 1 | External write strobe, active low |
| extLo | output | 8 | Low port: address low byte, then write data |
| extLoOe | output | 1 | Low port drive enable |
| extLoIn | input | 8 | Low port input data |
| extHi | output | 8 | High port: address high byte |
| extHiOe | output | 1 | High port drive enable |

## Verification
The case that needs care is a bypass-bit write (`cfgWe`) in the same cycle as an external-move request below 100h. The new bit value must not re-route that request. The bench drives `cfgWe` together with a pointer move to 00A0h in both directions, so the bit changes 0→1 and 1→0 while a request is live. The reference model samples the old bit for the routing decision before it applies the update. It then judges `ready`, the bus lines and `rdata` in that cycle and in the cycle after.

// File: rtl/mem_access_router_pkg.sv
package mem_access_router_pkg;

  typedef enum logic [1:0] {
    ACC_DIRECT   = 2'd0,
    ACC_INDIRECT = 2'd1,
    ACC_MOVX_REG = 2'd2,
    ACC_MOVX_PTR = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_LOW  = 3'd1,
    TGT_UP   = 3'd2,
    TGT_SFR  = 3'd3,
    TGT_XRAM = 3'd4,
    TGT_EXT  = 3'd5
  } tgt_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ALE  = 2'd1,
    PH_STB  = 2'd2,
    PH_REL  = 2'd3
  } phase_e;

  typedef struct packed {
    logic lowWe;
    logic upWe;
    logic xWe;
    logic latch;
    logic capture;
    logic ale;
    logic strobe;
    tgt_e rdSel;
  } ctl_strobes_t;

endpackage

// File: rtl/mem_access_router_ctrl.sv
module mem_access_router_ctrl
  import mem_access_router_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int XRAM_DEPTH = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqType,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              cfgWe,
  input  logic              cfgVal,
  output ctl_strobes_t      st,
  output logic              ready,
  output logic              sfrSel,
  output logic              sfrWe
);

  localparam int XRAM_AW = $clog2(XRAM_DEPTH);
  localparam int HALF_AW = DATA_W - 1;

  logic   bypassX;
  phase_e phase, phaseNext;
  tgt_e   tgt;
  acc_e   kind;
  logic   inUpperHalf;
  logic   belowXramTop;

  // Bypass bit: when set, all external moves leave the chip.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      bypassX <= 1'b0;
    else if (cfgWe) bypassX <= cfgVal;
  end

  assign kind         = acc_e'(reqType);
  assign inUpperHalf  = reqAddr[HALF_AW];
  assign belowXramTop = ((reqAddr >> XRAM_AW) == '0);

  // Target decode: the addressing mode splits the upper half between RAM and registers.
  always_comb begin
    tgt = TGT_NONE;
    if (reqValid) begin
      unique case (kind)
        ACC_DIRECT:   tgt = inUpperHalf ? TGT_SFR : TGT_LOW;
        ACC_INDIRECT: tgt = inUpperHalf ? TGT_UP  : TGT_LOW;
        ACC_MOVX_REG: tgt = bypassX ? TGT_EXT : TGT_XRAM;
        ACC_MOVX_PTR: tgt = (!bypassX && belowXramTop) ? TGT_XRAM : TGT_EXT;
        default:      tgt = TGT_NONE;
      endcase
    end
  end

  // External bus sequencer.
  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: if (tgt == TGT_EXT) phaseNext = PH_ALE;
      PH_ALE:  phaseNext = PH_STB;
      PH_STB:  phaseNext = PH_REL;
      PH_REL:  phaseNext = PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  logic idleNow;
  assign idleNow = (phase == PH_IDLE);

  always_comb begin
    st.lowWe   = idleNow && (tgt == TGT_LOW)  && reqWrite;
    st.upWe    = idleNow && (tgt == TGT_UP)   && reqWrite;
    st.xWe     = idleNow && (tgt == TGT_XRAM) && reqWrite;
    st.latch   = idleNow && (tgt == TGT_EXT);
    st.capture = (phase == PH_STB);
    st.ale     = (phase == PH_ALE);
    st.strobe  = (phase == PH_STB);
    st.rdSel   = idleNow ? tgt : TGT_EXT;
  end

  assign ready  = (phase == PH_REL) || (idleNow && (tgt != TGT_EXT));
  assign sfrSel = idleNow && (tgt == TGT_SFR);
  assign sfrWe  = sfrSel && reqWrite;

  // R4: a configuration write lands exactly one edge later.
  p_cfg_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> (bypassX == $past(cfgVal)));

  // R9: the core is stalled during the address phase.
  p_ext_stall_r9: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_ALE) |-> !ready);

  // R9: the strobe phase is always followed by release with ready high.
  p_release_ready_r9: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_STB) |=> ready);

  // R11: a register-port access never stalls.
  p_sfr_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    sfrSel |-> ready);

endmodule

// File: rtl/mem_access_router_datapath.sv
module mem_access_router_datapath
  import mem_access_router_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int XRAM_DEPTH = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobes_t      st,
  input  logic [1:0]        reqType,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] sfrRdata,
  input  logic [DATA_W-1:0] extLoIn,
  output logic [DATA_W-1:0] rdata,
  output logic              extAle,
  output logic              extRdN,
  output logic              extWrN,
  output logic [DATA_W-1:0] extLo,
  output logic              extLoOe,
  output logic [ADDR_W-DATA_W-1:0] extHi,
  output logic              extHiOe
);

  localparam int HALF_AW    = DATA_W - 1;
  localparam int HALF_DEPTH = 1 << HALF_AW;
  localparam int XRAM_AW    = $clog2(XRAM_DEPTH);
  localparam int HI_W       = ADDR_W - DATA_W;

  logic [DATA_W-1:0] lowMem [HALF_DEPTH];
  logic [DATA_W-1:0] upMem  [HALF_DEPTH];
  logic [DATA_W-1:0] xMem   [XRAM_DEPTH];

  logic [HALF_AW-1:0] halfIdx;
  logic [XRAM_AW-1:0] xIdx;
  assign halfIdx = reqAddr[HALF_AW-1:0];
  assign xIdx    = reqAddr[XRAM_AW-1:0];

  always_ff @(posedge clk) begin
    if (st.lowWe) lowMem[halfIdx] <= reqWdata;
    if (st.upWe)  upMem[halfIdx]  <= reqWdata;
    if (st.xWe)   xMem[xIdx]      <= reqWdata;
  end

  // Latched external request and captured read byte.
  logic [ADDR_W-1:0] latAddr;
  logic [DATA_W-1:0] latWdata;
  logic              latWrite;
  logic              latPtr;
  logic [DATA_W-1:0] capData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latAddr  <= '0;
      latWdata <= '0;
      latWrite <= 1'b0;
      latPtr   <= 1'b0;
      capData  <= '0;
    end else begin
      if (st.latch) begin
        latPtr   <= (acc_e'(reqType) == ACC_MOVX_PTR);
        latAddr  <= (acc_e'(reqType) == ACC_MOVX_PTR) ? reqAddr
                                                      : ADDR_W'(reqAddr[DATA_W-1:0]);
        latWdata <= reqWdata;
        latWrite <= reqWrite;
      end
      if (st.capture && !latWrite) capData <= extLoIn;
    end
  end

  // Return path: only the selected target reaches the core.
  always_comb begin
    unique case (st.rdSel)
      TGT_LOW:  rdata = lowMem[halfIdx];
      TGT_UP:   rdata = upMem[halfIdx];
      TGT_SFR:  rdata = sfrRdata;
      TGT_XRAM: rdata = xMem[xIdx];
      TGT_EXT:  rdata = capData;
      default:  rdata = '0;
    endcase
  end

  // Multiplexed bus drive, one phase per cycle.
  always_comb begin
    extAle  = 1'b0;
    extRdN  = 1'b1;
    extWrN  = 1'b1;
    extLo   = '0;
    extLoOe = 1'b0;
    extHi   = '0;
    extHiOe = 1'b0;
    if (st.ale) begin
      extAle  = 1'b1;
      extLo   = latAddr[DATA_W-1:0];
      extLoOe = 1'b1;
      extHiOe = latPtr;
      extHi   = latPtr ? latAddr[ADDR_W-1:DATA_W] : HI_W'(0);
    end
    if (st.strobe) begin
      extHiOe = latPtr;
      extHi   = latPtr ? latAddr[ADDR_W-1:DATA_W] : HI_W'(0);
      if (latWrite) begin
        extWrN  = 1'b0;
        extLo   = latWdata;
        extLoOe = 1'b1;
      end else begin
        extRdN  = 1'b0;
      end
    end
  end

  // R9: at most one of latch enable, read strobe, write strobe at a time.
  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({extAle, !extRdN, !extWrN}));

  // R10: the byte seen during a read strobe is what the core gets next cycle.
  p_capture_r10: assert property (@(posedge clk) disable iff (!rstN)
    !extRdN |=> (rdata == $past(extLoIn)));

  // R8: expanded-RAM hits keep the bus quiet.
  p_xram_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (st.rdSel == TGT_XRAM) |-> (extRdN && extWrN && !extAle && !extLoOe && !extHiOe));

endmodule

// File: rtl/mem_access_router.sv
module mem_access_router
  import mem_access_router_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int XRAM_DEPTH = 256
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic [1:0]               reqType,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic                     reqWrite,
  input  logic [DATA_W-1:0]        reqWdata,
  output logic [DATA_W-1:0]        rdata,
  output logic                     ready,
  input  logic                     cfgWe,
  input  logic                     cfgVal,
  output logic                     sfrSel,
  output logic                     sfrWe,
  output logic [DATA_W-1:0]        sfrAddr,
  output logic [DATA_W-1:0]        sfrWdata,
  input  logic [DATA_W-1:0]        sfrRdata,
  output logic                     extAle,
  output logic                     extRdN,
  output logic                     extWrN,
  output logic [DATA_W-1:0]        extLo,
  output logic                     extLoOe,
  input  logic [DATA_W-1:0]        extLoIn,
  output logic [ADDR_W-DATA_W-1:0] extHi,
  output logic                     extHiOe
);

  ctl_strobes_t st;

  mem_access_router_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .XRAM_DEPTH(XRAM_DEPTH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqType(reqType),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .cfgWe(cfgWe), .cfgVal(cfgVal),
    .st(st), .ready(ready), .sfrSel(sfrSel), .sfrWe(sfrWe)
  );

  mem_access_router_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .XRAM_DEPTH(XRAM_DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .reqType(reqType), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqWdata(reqWdata), .sfrRdata(sfrRdata),
    .extLoIn(extLoIn), .rdata(rdata), .extAle(extAle), .extRdN(extRdN),
    .extWrN(extWrN), .extLo(extLo), .extLoOe(extLoOe), .extHi(extHi),
    .extHiOe(extHiOe)
  );

  assign sfrAddr  = reqAddr[DATA_W-1:0];
  assign sfrWdata = reqWdata;

  // R3: register-port selection is confined to direct accesses.
  p_sfr_direct_only_r3: assert property (@(posedge clk) disable iff (!rstN)
    sfrSel |-> (reqValid && (reqType == 2'd0) && sfrAddr[DATA_W-1]));

endmodule

// File: tb/tb_mem_access_router.sv
module tb_mem_access_router;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqType = 2'd0;
  logic [15:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic [7:0]  reqWdata = '0;
  logic [7:0]  rdata;
  logic        ready;
  logic        cfgWe = 1'b0;
  logic        cfgVal = 1'b0;
  logic        sfrSel, sfrWe;
  logic [7:0]  sfrAddr, sfrWdata, sfrRdata;
  logic        extAle, extRdN, extWrN, extLoOe, extHiOe;
  logic [7:0]  extLo, extHi;
  logic [7:0]  extLoIn = '0;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sfrRdata = sfrAddr ^ 8'h5A;

  mem_access_router dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqType(reqType),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .rdata(rdata), .ready(ready), .cfgWe(cfgWe), .cfgVal(cfgVal),
    .sfrSel(sfrSel), .sfrWe(sfrWe), .sfrAddr(sfrAddr), .sfrWdata(sfrWdata),
    .sfrRdata(sfrRdata), .extAle(extAle), .extRdN(extRdN), .extWrN(extWrN),
    .extLo(extLo), .extLoOe(extLoOe), .extLoIn(extLoIn), .extHi(extHi),
    .extHiOe(extHiOe)
  );

  // ---------------- reference model ----------------
  byte unsigned lowM [128];
  byte unsigned upM  [128];
  byte unsigned xM   [256];
  bit lowW [128];
  bit upW  [128];
  bit xW   [256];
  bit bypassM = 0;
  int phaseM = 0;
  int latA = 0;
  bit latWr = 0;
  bit latPtr = 0;
  int latD = 0;
  int capM = 0;

  function automatic int tgtOf(bit v, int t, int a, bit byp);
    if (!v) return 0;
    if (t < 2) return ((a & 'h80) == 0) ? 1 : ((t == 0) ? 3 : 2);
    if (t == 2) return byp ? 5 : 4;
    return (byp || a > 'hFF) ? 5 : 4;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rstN) begin
      int t;
      int a;
      t = tgtOf(reqValid, reqType, reqAddr, bypassM);
      a = reqAddr;
      case (phaseM)
        0: begin
          if (reqWrite && t == 1) begin lowM[a & 'h7F] = reqWdata; lowW[a & 'h7F] = 1; end
          if (reqWrite && t == 2) begin upM[a & 'h7F] = reqWdata; upW[a & 'h7F] = 1; end
          if (reqWrite && t == 4) begin xM[a & 'hFF] = reqWdata; xW[a & 'hFF] = 1; end
          if (t == 5) begin
            latPtr = (reqType == 2'd3);
            latA   = latPtr ? a : (a & 'hFF);
            latWr  = reqWrite;
            latD   = reqWdata;
            phaseM = 1;
          end
        end
        1: phaseM = 2;
        2: begin
          if (!latWr) capM = extLoIn;
          phaseM = 3;
        end
        default: phaseM = 0;
      endcase
      if (cfgWe) bypassM = cfgVal;
    end
  end

  // Per-cycle comparison, sampled mid-cycle.
  always @(negedge clk) begin
    if (rstN) begin
      int t;
      int a;
      t = tgtOf(reqValid, reqType, reqAddr, bypassM);
      a = reqAddr;
      case (phaseM)
        0: begin
          if (t == 5) chk(bypassM ? "R7" : "R6", "ready", ready, 0);
          else        chk("R11", "ready", ready, 1);
          chk("R8", "idle bus", {extAle, extRdN, extWrN, extLoOe, extHiOe}, 5'b01100);
          chk("R3", "sfrSel", sfrSel, (t == 3));
          if (t == 3) begin
            chk("R3", "sfrWe", sfrWe, reqWrite);
            chk("R3", "sfrAddr", sfrAddr, a & 'hFF);
            if (reqWrite) chk("R3", "sfrWdata", sfrWdata, reqWdata);
            else          chk("R3", "sfr rdata", rdata, (a & 'hFF) ^ 'h5A);
          end
          if (!reqWrite && t == 1 && lowW[a & 'h7F]) chk("R1", "low rdata", rdata, lowM[a & 'h7F]);
          if (!reqWrite && t == 2 && upW[a & 'h7F])  chk("R2", "up rdata", rdata, upM[a & 'h7F]);
          if (!reqWrite && t == 4 && xW[a & 'hFF])   chk("R5", "xram rdata", rdata, xM[a & 'hFF]);
        end
        1: begin
          chk("R9", "ready addr phase", ready, 0);
          chk("R9", "ale/strobes", {extAle, extRdN, extWrN}, 3'b111);
          chk("R9", "lo addr", extLo, latA & 'hFF);
          chk("R9", "loOe addr", extLoOe, 1);
          chk("R9", "hiOe addr", extHiOe, latPtr);
          if (latPtr) chk("R9", "hi addr", extHi, (latA >> 8) & 'hFF);
        end
        2: begin
          chk("R9", "ready strobe", ready, 0);
          chk("R9", "strobes", {extAle, extRdN, extWrN}, latWr ? 3'b010 : 3'b001);
          chk("R9", "loOe strobe", extLoOe, latWr);
          if (latWr) chk("R9", "write data", extLo, latD);
          chk("R9", "hiOe strobe", extHiOe, latPtr);
          if (latPtr) chk("R9", "hi strobe", extHi, (latA >> 8) & 'hFF);
        end
        default: begin
          chk("R9", "ready release", ready, 1);
          chk("R9", "bus released", {extAle, extRdN, extWrN, extLoOe, extHiOe}, 5'b01100);
          if (!latWr) chk("R10", "ext rdata", rdata, capM);
        end
      endcase
    end
  end

  // ---------------- stimulus ----------------
  task automatic access(int t, int a, bit w, int d, int ein);
    reqValid = 1'b1;
    reqType  = t[1:0];
    reqAddr  = a[15:0];
    reqWrite = w;
    reqWdata = d[7:0];
    extLoIn  = ein[7:0];
    forever begin
      @(negedge clk);
      if (ready) break;
    end
    @(posedge clk);
    #1;
    cfgWe    = 1'b0;
    reqValid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    // R4: after reset the expanded RAM is active: a low pointer move does not stall
    reqValid = 1'b1; reqType = 2'd3; reqAddr = 16'h0040; reqWrite = 1'b1; reqWdata = 8'h0F;
    @(negedge clk);
    chk("R4", "ready after reset", ready, 1);
    @(posedge clk); #1; reqValid = 1'b0;

    // R1: direct and indirect share lower RAM; high address bits ignored
    access(0, 'h0005, 1, 'h11, 0);
    access(1, 'h0005, 0, 0, 0);
    access(1, 'h007F, 1, 'h22, 0);
    access(0, 'h127F, 0, 0, 0);
    // R2 / R3: upper RAM and register port are separate
    access(1, 'h0090, 1, 'hAA, 0);
    access(0, 'h0090, 1, 'h55, 0);
    access(1, 'h0090, 0, 0, 0);
    access(0, 'h0090, 0, 0, 0);
    access(1, 'h0080, 1, 'h77, 0);
    access(0, 'h0080, 0, 0, 0);
    access(1, 'h0080, 0, 0, 0);
    // R5: expanded RAM shared by both pointer kinds
    access(3, 'h00A0, 1, 'h33, 0);
    access(2, 'h00A0, 0, 0, 0);
    access(2, 'h00FF, 1, 'h44, 0);
    access(3, 'h00FF, 0, 0, 0);
    access(3, 'h0040, 0, 0, 0);
    // R6 / R10: above the expanded window goes out on the bus
    access(3, 'h1234, 1, 'h66, 'h00);
    access(3, 'h8001, 0, 0, 'hC3);
    access(3, 'h0100, 0, 0, 'h5E);
    // R4: bypass written in the same cycle as a low pointer move; old value routes it
    cfgWe = 1'b1; cfgVal = 1'b1;
    access(3, 'h00A0, 0, 0, 'hEE);
    // R7: everything external now
    access(3, 'h00A0, 0, 0, 'h9E);
    access(2, 'h0010, 1, 'h5A, 0);
    access(2, 'h00A0, 0, 0, 'h3C);
    access(3, 'h00FF, 1, 'h99, 0);
    // R4: clear again together with an external-bound request
    cfgWe = 1'b1; cfgVal = 1'b0;
    access(3, 'h00A0, 0, 0, 'h71);
    access(3, 'h00A0, 0, 0, 'h00);
    access(3, 'h00FF, 0, 0, 'h00);
    // back-to-back mix
    access(0, 'h0005, 0, 0, 0);
    access(3, 'hFFFF, 0, 0, 'hA5);
    access(1, 'h00FE, 1, 'h12, 0);
    access(1, 'h00FE, 0, 0, 0);
    idle(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule